// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit makes every hazard decision for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It compares the source register numbers of the instructions in decode and execute against the destination numbers of the older instructions further down the pipe. From those comparisons it drives the bypass multiplexer selects for both execute operands and both decode operands, the load-use interlock, and the squash of wrong-path work after a taken branch. The datapath multiplexers themselves are outside the unit. It only produces their select lines.

Arithmetic dependences are resolved by forwarding alone. An instruction that consumes a loaded register in the cycle right after the load is held in decode for one cycle while a bubble enters execute. The register file does not return a value that is written in the same cycle, so a writeback-to-decode bypass covers that gap. Branches resolve in the memory stage. A taken branch discards the three younger instructions behind it, and the squash takes precedence over any stall raised in the same cycle.

All decisions are combinational. The clock and active-low reset are used only to time the built-in property checks.

Top module: `hz_ctrl`

## Requirements
- R1: An execute operand selects the memory-stage result (select code 2'b10) when the memory-stage write enable is high, its destination is nonzero, and the destination equals that operand's source register.
- R2: An execute operand selects the writeback result (code 2'b01) when only the writeback stage matches it under the same conditions. With no match, it selects the register-file value (code 2'b00).
- R3: When both the memory and writeback stages match an execute operand, the memory-stage result (2'b10) is selected.
- R4: Register 0 never causes forwarding, bypass or a stall, and neither does a producer whose write enable is low.
- R5: A decode operand bypass select is 1 (take the writeback value) when the writeback write enable is high, the writeback destination is nonzero, and it equals that decode source. Otherwise the select is 0.
- R6: When execute holds a load with write enable high and a nonzero destination that equals either decode source, the front-end stall and the execute bubble are both 1.
- R7: A non-load producer in execute never raises the stall or the bubble, whatever its destination.
- R8: A taken branch raises all three flushes (fetch/decode, decode/execute, execute/memory) and forces the stall and bubble to 0. With no taken branch, all flushes are 0.
- R9: The second execute operand, which also carries a store's data, is forwarded by the same rules as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, times the property checks only |
| rst_n | input | 1 | Active-low reset for the property checks |
| id_rs | input | REG_AW | Decode first source register |
| id_rt | input | REG_AW | Decode second source register |
| ex_rs | input | REG_AW | Execute first source register |
| ex_rt | input | REG_AW | Execute second source / store data register |
| ex_rd | input | REG_AW | Execute destination register |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage write enable |
| wb_rd | input | REG_AW | Writeback destination register |
| wb_we | input | 1 | Writeback write enable |
| br_taken | input | 1 | Branch in memory stage is taken |
| ex_fwd_a | output | 2 | First execute operand select |
| ex_fwd_b | output | 2 | Second execute operand select |
| id_byp_a | output | 1 | First decode operand writeback bypass |
| id_byp_b | output | 1 | Second decode operand writeback bypass |
| stall_front | output | 1 | Hold PC and fetch/decode register |
| bubble_ex | output | 1 | Insert a bubble into execute |
| flush_if_id | output | 1 | Squash fetch/decode register |
| flush_id_ex | output | 1 | Squash decode/execute register |
| flush_ex_mem | output | 1 | Squash execute/memory register |

## Verification
The hardest situation to create from the ports is a taken branch that arrives in the same cycle as a load-use match. A running pipeline rarely lines up a dependent load pair just behind a resolving branch. The bench drives that combination directly and checks that all flushes rise while the stall and bubble stay low. It also uses a case where the memory and writeback destinations are equal and both writing, to confirm the memory-stage priority, and repeats that pattern with register 0 to confirm that neither path fires.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic stall;
        logic bubble;
        logic fl_if_id;
        logic fl_id_ex;
        logic fl_ex_mem;
    } intlk_t;
endpackage

// File: rtl/hz_fwd_ex.sv
module hz_fwd_ex
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output fwd_sel_e          sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    fwd_sel_e sel_d;
    logic     mem_hit_d;
    logic     wb_hit_d;

    always_comb begin
        mem_hit_d = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
        wb_hit_d  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
        if (mem_hit_d)     sel_d = FWD_MEM;
        else if (wb_hit_d) sel_d = FWD_WB;
        else               sel_d = FWD_RF;
    end

    assign sel = sel_d;
endmodule

// File: rtl/hz_byp_id.sv
module hz_byp_id #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic              byp
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic byp_d;

    always_comb begin
        byp_d = wb_we && (wb_rd != ZERO_REG) && (wb_rd == src);
    end

    assign byp = byp_d;
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_load,
    input  logic              br_taken,
    output intlk_t            ctl
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    intlk_t ctl_d;
    logic   use_hit_d;

    always_comb begin
        use_hit_d = ex_load && ex_we && (ex_rd != ZERO_REG)
                    && ((ex_rd == id_rs) || (ex_rd == id_rt));
        ctl_d = '0;
        if (br_taken) begin
            // squash wins over any interlock in the same cycle
            ctl_d.fl_if_id  = 1'b1;
            ctl_d.fl_id_ex  = 1'b1;
            ctl_d.fl_ex_mem = 1'b1;
        end else if (use_hit_d) begin
            ctl_d.stall  = 1'b1;
            ctl_d.bubble = 1'b1;
        end
    end

    assign ctl = ctl_d;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    input  logic              br_taken,
    output logic [1:0]        ex_fwd_a,
    output logic [1:0]        ex_fwd_b,
    output logic              id_byp_a,
    output logic              id_byp_b,
    output logic              stall_front,
    output logic              bubble_ex,
    output logic              flush_if_id,
    output logic              flush_id_ex,
    output logic              flush_ex_mem
);
    localparam int N_OPS = 2;
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [REG_AW-1:0] ex_src [N_OPS];
    logic [REG_AW-1:0] id_src [N_OPS];
    fwd_sel_e          ex_sel [N_OPS];
    logic              id_sel [N_OPS];
    intlk_t            ctl;

    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;
    assign id_src[0] = id_rs;
    assign id_src[1] = id_rt;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        hz_fwd_ex #(.REG_AW(REG_AW)) u_fwd (
            .src    (ex_src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (ex_sel[g])
        );
        hz_byp_id #(.REG_AW(REG_AW)) u_byp (
            .src   (id_src[g]),
            .wb_rd (wb_rd),
            .wb_we (wb_we),
            .byp   (id_sel[g])
        );
    end

    hz_interlock #(.REG_AW(REG_AW)) u_intlk (
        .id_rs    (id_rs),
        .id_rt    (id_rt),
        .ex_rd    (ex_rd),
        .ex_we    (ex_we),
        .ex_load  (ex_load),
        .br_taken (br_taken),
        .ctl      (ctl)
    );

    assign ex_fwd_a     = ex_sel[0];
    assign ex_fwd_b     = ex_sel[1];
    assign id_byp_a     = id_sel[0];
    assign id_byp_b     = id_sel[1];
    assign stall_front  = ctl.stall;
    assign bubble_ex    = ctl.bubble;
    assign flush_if_id  = ctl.fl_if_id;
    assign flush_id_ex  = ctl.fl_id_ex;
    assign flush_ex_mem = ctl.fl_ex_mem;

    // R1 / R3: a memory-stage match always wins
    a_r3_mem_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != ZERO_REG && mem_rd == ex_rs) |-> ex_fwd_a == 2'b10);
    // R1: memory select only with a writing producer
    a_r1_mem_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_fwd_b == 2'b10) |-> mem_we);
    // R4: register 0 is never forwarded or bypassed
    a_r4_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == ZERO_REG) |-> (ex_fwd_a == 2'b00));
    // R5: decode bypass requires a writing writeback stage
    a_r5_byp_needs_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (id_byp_a || id_byp_b) |-> wb_we);
    // R6: stall and bubble travel together
    a_r6_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front == bubble_ex);
    // R7: only a load can interlock
    a_r7_alu_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !stall_front);
    // R8: squash overrides the interlock
    a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (flush_if_id && flush_id_ex && flush_ex_mem && !stall_front && !bubble_ex));
    a_r8_no_spurious_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> !(flush_if_id || flush_id_ex || flush_ex_mem));
endmodule

// File: tb/hz_ctrl_bench.sv
module hz_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic       ex_we, ex_load, mem_we, wb_we, br_taken;
    logic [1:0] ex_fwd_a, ex_fwd_b;
    logic       id_byp_a, id_byp_b, stall_front, bubble_ex;
    logic       flush_if_id, flush_id_ex, flush_ex_mem;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    hz_ctrl u_hz_ctrl (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .br_taken(br_taken),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
        .id_byp_a(id_byp_a), .id_byp_b(id_byp_b),
        .stall_front(stall_front), .bubble_ex(bubble_ex),
        .flush_if_id(flush_if_id), .flush_id_ex(flush_id_ex),
        .flush_ex_mem(flush_ex_mem)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        id_rs = 0; id_rt = 0; ex_rs = 0; ex_rt = 0; ex_rd = 0;
        mem_rd = 0; wb_rd = 0;
        ex_we = 0; ex_load = 0; mem_we = 0; wb_we = 0; br_taken = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        idle(); settle();
        chk("R2 idle fwd_a", ex_fwd_a, 0);
        chk("R2 idle fwd_b", ex_fwd_b, 0);
        chk("R8 idle flush", {flush_if_id, flush_id_ex, flush_ex_mem}, 0);
        chk("R6 idle stall", {stall_front, bubble_ex}, 0);
    endtask

    task automatic t_mem_fwd();
        idle(); ex_rs = 7; mem_rd = 7; mem_we = 1; settle();
        chk("R1 mem fwd a", ex_fwd_a, 2);
        chk("R1 other op untouched", ex_fwd_b, 0);
    endtask

    task automatic t_wb_fwd();
        idle(); ex_rs = 9; wb_rd = 9; wb_we = 1; mem_rd = 4; mem_we = 1; settle();
        chk("R2 wb fwd a", ex_fwd_a, 1);
    endtask

    task automatic t_priority();
        idle(); ex_rs = 12; ex_rt = 12; mem_rd = 12; wb_rd = 12;
        mem_we = 1; wb_we = 1; settle();
        chk("R3 prio a", ex_fwd_a, 2);
        chk("R3 prio b", ex_fwd_b, 2);
    endtask

    task automatic t_zero();
        idle(); ex_rs = 0; ex_rt = 0; id_rs = 0; mem_we = 1; wb_we = 1; settle();
        chk("R4 zero fwd a", ex_fwd_a, 0);
        chk("R4 zero byp a", id_byp_a, 0);
        idle(); ex_rs = 5; mem_rd = 5; wb_rd = 5; id_rs = 5; settle();
        chk("R4 we low fwd", ex_fwd_a, 0);
        chk("R4 we low byp", id_byp_a, 0);
        idle(); id_rs = 0; ex_rd = 0; ex_we = 1; ex_load = 1; settle();
        chk("R4 zero load no stall", stall_front, 0);
        idle(); id_rs = 3; ex_rd = 3; ex_we = 0; ex_load = 1; settle();
        chk("R4 we low load no stall", stall_front, 0);
    endtask

    task automatic t_dec_byp();
        idle(); id_rs = 8; id_rt = 11; wb_rd = 11; wb_we = 1; settle();
        chk("R5 byp a off", id_byp_a, 0);
        chk("R5 byp b on", id_byp_b, 1);
        id_rs = 11; settle();
        chk("R5 byp a on", id_byp_a, 1);
    endtask

    task automatic t_load_use();
        idle(); id_rt = 6; ex_rd = 6; ex_we = 1; ex_load = 1; settle();
        chk("R6 stall rt", stall_front, 1);
        chk("R6 bubble rt", bubble_ex, 1);
        id_rt = 2; id_rs = 6; settle();
        chk("R6 stall rs", stall_front, 1);
        id_rs = 1; settle();
        chk("R6 no match", stall_front, 0);
    endtask

    task automatic t_alu_no_stall();
        idle(); id_rs = 6; ex_rd = 6; ex_we = 1; ex_load = 0; settle();
        chk("R7 alu stall", stall_front, 0);
        chk("R7 alu bubble", bubble_ex, 0);
    endtask

    task automatic t_branch();
        idle(); br_taken = 1; settle();
        chk("R8 flush all", {flush_if_id, flush_id_ex, flush_ex_mem}, 7);
        id_rs = 6; ex_rd = 6; ex_we = 1; ex_load = 1; settle();
        chk("R8 flush over stall", {flush_if_id, flush_id_ex, flush_ex_mem}, 7);
        chk("R8 stall suppressed", stall_front, 0);
        chk("R8 bubble suppressed", bubble_ex, 0);
        br_taken = 0; settle();
        chk("R8 flush drop", {flush_if_id, flush_id_ex, flush_ex_mem}, 0);
    endtask

    task automatic t_store_data();
        idle(); ex_rs = 3; ex_rt = 14; wb_rd = 14; wb_we = 1; settle();
        chk("R9 store wb fwd b", ex_fwd_b, 1);
        chk("R9 a untouched", ex_fwd_a, 0);
        mem_rd = 14; mem_we = 1; settle();
        chk("R9 store mem fwd b", ex_fwd_b, 2);
    endtask

    initial begin
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_zero();
        t_dec_byp();
        t_load_use();
        t_alu_no_stall();
        t_branch();
        t_store_data();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule